// File: doc/BRIEF.md
# PCM Time-Slot Window Generator

This block marks the bit periods in which a serial controller on a time-slot oriented PCM link may receive and transmit. Both directions use one externally supplied bit clock. A frame synchronization input restarts a count of clock periods. From that count the block derives two independent strobes, one for receive and one for transmit. Each strobe rises at a programmed position within the frame and stays high for a programmed number of bit periods.

Each direction has its own settings: a 6-bit slot number, a 3-bit clock shift and an 8-bit width code. The shift arrives in two parts. Its upper two bits travel with the slot number, and its lowest bit arrives on a separate input. The position is the 9-bit value `{slot, shift_hi, shift_lo}`, that is slot*8 + shift. The window opens 1 + position clock periods after the edge that samples sync, so the delay ranges from 1 to 512 periods. The width code is width minus one, which gives windows of 1 to 256 bits. All settings are captured on the sync edge. The data path, framing, clock generation and host access are handled elsewhere.

Top module: `tsw_window_gen`

## Requirements
- R1: While reset is low, and after reset until a frame sync has been sampled high, `rx_win` and `tx_win` are both 0. Reset acts asynchronously.
- R2: Call the rising clock edge that samples `fsync` high edge 0, and count the following edges 1, 2, 3 and so on. A window is high in the cycle after edge k exactly when S <= k < S + W. Here S = 1 + {slot, shift_hi, shift_lo}: the slot number is bits 8..3, shift_hi is bits 2..1 and shift_lo is bit 0.
- R3: The window width W is `width_m1` + 1. The code 0 gives 1 cycle and 255 gives 256 cycles.
- R4: The receive window depends only on the rx_* settings and the transmit window depends only on the tx_* settings. The two windows may overlap or coincide.
- R5: Settings are captured only on the edge that samples `fsync` high. Changing the setting inputs in the middle of a frame does not alter the current frame's windows.
- R6: A sync sampled while a window is pending or active restarts the count. Both windows are 0 in the cycle after that edge, and they follow the newly captured settings from then on.
- R7: Without a further sync, each window fires at most once per frame, however long the frame lasts.
- R8: The extreme positions work. Position 0 opens the window in the cycle after edge 1. Position 511 with code 255 keeps the window high from edge 512 through edge 767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared receive/transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame synchronization, sampled on the rising edge |
| rx_slot | input | 6 | Receive slot number |
| rx_shift_hi | input | 2 | Receive clock shift, upper two bits |
| rx_shift_lo | input | 1 | Receive clock shift, lowest bit |
| rx_width_m1 | input | 8 | Receive window width minus one |
| tx_slot | input | 6 | Transmit slot number |
| tx_shift_hi | input | 2 | Transmit clock shift, upper two bits |
| tx_shift_lo | input | 1 | Transmit clock shift, lowest bit |
| tx_width_m1 | input | 8 | Transmit window width minus one |
| rx_win | output | 1 | Receive time-slot strobe |
| tx_win | output | 1 | Transmit time-slot strobe |

## Verification
Two functions can land on the same clock edge: a fresh frame sync, and a window that is opening or still running. The bench provokes this by pulsing sync in two places. One pulse falls ten cycles into an open window. The other falls in the cycle before the edge on which a window would have opened. A reference count of edges since the last sampled sync then requires both strobes to be low in the next cycle, and it requires the windows to reopen at the positions captured on the new sync. A further check writes new settings mid-frame in the same run and confirms that the windows of the running frame stay as they were.

// File: rtl/tsw_pkg.sv
package tsw_pkg;

  // Larger of two widths, used to size the frame counter.
  function automatic int tsw_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tsw_frame_cnt.sv
module tsw_frame_cnt #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic [CNT_W-1:0] cnt,
  output logic             armed
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             cnt_en;

  // The counter advances every period and holds once it saturates.
  assign cnt_en = fsync | (cnt_q != CNT_MAX);

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (fsync) begin
      cnt_d   = '0;
      armed_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign cnt   = cnt_q;
  assign armed = armed_q;

endmodule

// File: rtl/tsw_chan.sv
module tsw_chan #(
  parameter int SLOT_W  = 6,
  parameter int SHIFT_W = 3,
  parameter int WIDTH_W = 8,
  parameter int CNT_W   = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fsync,
  input  logic               armed,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [SLOT_W-1:0]  slot,
  input  logic [SHIFT_W-2:0] shift_hi,
  input  logic               shift_lo,
  input  logic [WIDTH_W-1:0] width_m1,
  output logic               win
);

  localparam int POS_W = SLOT_W + SHIFT_W;

  logic [POS_W-1:0] pos;
  logic [CNT_W-1:0] start_d, stop_d;
  logic [CNT_W-1:0] start_q, stop_q;
  logic             cfg_en;

  assign pos    = {slot, shift_hi, shift_lo};
  assign cfg_en = fsync;

  // The bounds are computed here, so the comparators need no adder.
  always_comb begin
    start_d = CNT_W'(pos) + CNT_W'(1);
    stop_d  = start_d + CNT_W'(width_m1) + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      stop_q  <= '0;
    end else if (cfg_en) begin
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end

  assign win = armed && (cnt >= start_q) && (cnt < stop_q);

endmodule

// File: rtl/tsw_window_gen.sv
module tsw_window_gen #(
  parameter int SLOT_W  = 6,
  parameter int SHIFT_W = 3,
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fsync,
  input  logic [SLOT_W-1:0]  rx_slot,
  input  logic [SHIFT_W-2:0] rx_shift_hi,
  input  logic               rx_shift_lo,
  input  logic [WIDTH_W-1:0] rx_width_m1,
  input  logic [SLOT_W-1:0]  tx_slot,
  input  logic [SHIFT_W-2:0] tx_shift_hi,
  input  logic               tx_shift_lo,
  input  logic [WIDTH_W-1:0] tx_width_m1,
  output logic               rx_win,
  output logic               tx_win
);

  localparam int POS_W  = SLOT_W + SHIFT_W;
  // Two spare bits: the saturated count always lies beyond every window end.
  localparam int CNT_W  = tsw_pkg::tsw_max(POS_W, WIDTH_W) + 2;
  localparam int N_CHAN = 2;

  logic [CNT_W-1:0]   cnt;
  logic               armed;
  logic [SLOT_W-1:0]  slot_a   [N_CHAN];
  logic [SHIFT_W-2:0] shhi_a   [N_CHAN];
  logic               shlo_a   [N_CHAN];
  logic [WIDTH_W-1:0] wid_a    [N_CHAN];
  logic               win_a    [N_CHAN];

  assign slot_a[0] = rx_slot;     assign slot_a[1] = tx_slot;
  assign shhi_a[0] = rx_shift_hi; assign shhi_a[1] = tx_shift_hi;
  assign shlo_a[0] = rx_shift_lo; assign shlo_a[1] = tx_shift_lo;
  assign wid_a[0]  = rx_width_m1; assign wid_a[1]  = tx_width_m1;

  tsw_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .fsync (fsync),
    .cnt   (cnt),
    .armed (armed)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    tsw_chan #(
      .SLOT_W  (SLOT_W),
      .SHIFT_W (SHIFT_W),
      .WIDTH_W (WIDTH_W),
      .CNT_W   (CNT_W)
    ) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .fsync    (fsync),
      .armed    (armed),
      .cnt      (cnt),
      .slot     (slot_a[c]),
      .shift_hi (shhi_a[c]),
      .shift_lo (shlo_a[c]),
      .width_m1 (wid_a[c]),
      .win      (win_a[c])
    );
  end

  assign rx_win = win_a[0];
  assign tx_win = win_a[1];

endmodule

// File: rtl/tsw_window_gen_chk.sv
module tsw_window_gen_chk #(
  parameter int SLOT_W  = 6,
  parameter int SHIFT_W = 3,
  parameter int WIDTH_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fsync,
  input logic [SLOT_W-1:0]  rx_slot,
  input logic [SHIFT_W-2:0] rx_shift_hi,
  input logic               rx_shift_lo,
  input logic [WIDTH_W-1:0] rx_width_m1,
  input logic               rx_win,
  input logic               tx_win
);

  localparam int POS_W = SLOT_W + SHIFT_W;
  localparam int K_W   = POS_W + 3;

  logic               seen_q, fs_q, rxw_q, done_q;
  logic [K_W-1:0]     k_q;
  logic [POS_W-1:0]   pos_q;
  logic [WIDTH_W-1:0] wid_q;
  logic [WIDTH_W:0]   len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      fs_q   <= 1'b0;
      rxw_q  <= 1'b0;
      done_q <= 1'b0;
      k_q    <= '0;
      pos_q  <= '0;
      wid_q  <= '0;
      len_q  <= '0;
    end else begin
      fs_q  <= fsync;
      rxw_q <= rx_win;
      len_q <= rx_win ? len_q + 1'b1 : '0;
      if (fsync) begin
        seen_q <= 1'b1;
        k_q    <= '0;
        pos_q  <= {rx_slot, rx_shift_hi, rx_shift_lo};
        wid_q  <= rx_width_m1;
        done_q <= 1'b0;
      end else begin
        if (k_q != '1) k_q <= k_q + 1'b1;
        if (rxw_q && !rx_win && !fs_q) done_q <= 1'b1;
      end
    end
  end

  AST_QUIET_BEFORE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (!rx_win && !tx_win)); // R1

  AST_RX_OPENS_AT_POS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_win) |-> (k_q == K_W'(pos_q) + K_W'(1))); // R2

  AST_RX_WIDTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_win |-> (len_q <= (WIDTH_W+1)'(wid_q))); // R3

  AST_SYNC_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |=> (!rx_win && !tx_win)); // R6

  AST_ONCE_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !rx_win); // R7

endmodule

bind tsw_window_gen tsw_window_gen_chk #(
  .SLOT_W  (SLOT_W),
  .SHIFT_W (SHIFT_W),
  .WIDTH_W (WIDTH_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fsync       (fsync),
  .rx_slot     (rx_slot),
  .rx_shift_hi (rx_shift_hi),
  .rx_shift_lo (rx_shift_lo),
  .rx_width_m1 (rx_width_m1),
  .rx_win      (rx_win),
  .tx_win      (tx_win)
);

// File: tb/tsw_window_gen_test.sv
module tsw_window_gen_test;

  logic       clk = 1'b0;
  logic       rst_n, fsync;
  logic [5:0] rx_slot, tx_slot;
  logic [1:0] rx_shift_hi, tx_shift_hi;
  logic       rx_shift_lo, tx_shift_lo;
  logic [7:0] rx_width_m1, tx_width_m1;
  logic       rx_win, tx_win;

  int nchk = 0;
  int nerr = 0;
  int mk, m_rs, m_re, m_ts, m_te;
  bit marm;

  always #10 clk = ~clk;

  tsw_window_gen uut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .rx_slot(rx_slot), .rx_shift_hi(rx_shift_hi), .rx_shift_lo(rx_shift_lo),
    .rx_width_m1(rx_width_m1),
    .tx_slot(tx_slot), .tx_shift_hi(tx_shift_hi), .tx_shift_lo(tx_shift_lo),
    .tx_width_m1(tx_width_m1),
    .rx_win(rx_win), .tx_win(tx_win)
  );

  // {rx slot, rx shift, rx code, tx slot, tx shift, tx code, frame length}
  localparam logic [43:0] VEC [8] = '{
    {6'd0,  3'd0, 8'd7,   6'd1,  3'd0, 8'd7,   10'd30},
    {6'd3,  3'd5, 8'd15,  6'd2,  3'd1, 8'd3,   10'd60},
    {6'd0,  3'd1, 8'd0,   6'd0,  3'd1, 8'd0,   10'd10},
    {6'd10, 3'd2, 8'd31,  6'd9,  3'd7, 8'd63,  10'd200},
    {6'd63, 3'd7, 8'd255, 6'd0,  3'd0, 8'd255, 10'd800},
    {6'd5,  3'd0, 8'd99,  6'd40, 3'd3, 8'd0,   10'd400},
    {6'd31, 3'd4, 8'd200, 6'd32, 3'd0, 8'd10,  10'd500},
    {6'd1,  3'd3, 8'd2,   6'd1,  3'd3, 8'd2,   10'd20}
  };

  task automatic check(input string tag, input string nm, input logic got, input logic exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s %s got %b expected %b (edge %0d since sync)", tag, nm, got, exp, mk);
    end
  endtask

  task automatic set_cfg(input int rs, input int rsh, input int rw,
                         input int ts, input int tsh, input int tw);
    rx_slot = 6'(rs); {rx_shift_hi, rx_shift_lo} = 3'(rsh); rx_width_m1 = 8'(rw);
    tx_slot = 6'(ts); {tx_shift_hi, tx_shift_lo} = 3'(tsh); tx_width_m1 = 8'(tw);
  endtask

  // One clock period: update the reference model at the edge and compare at the falling edge.
  task automatic step(input string tag);
    @(posedge clk);
    if (fsync) begin
      mk   = 0;
      marm = 1'b1;
      m_rs = 1 + int'({rx_slot, rx_shift_hi, rx_shift_lo});
      m_re = m_rs + int'(rx_width_m1) + 1;
      m_ts = 1 + int'({tx_slot, tx_shift_hi, tx_shift_lo});
      m_te = m_ts + int'(tx_width_m1) + 1;
    end else if (mk < 4095) begin
      mk++;
    end
    @(negedge clk);
    check(tag, "rx_win", rx_win, marm && mk >= m_rs && mk < m_re);
    check(tag, "tx_win", tx_win, marm && mk >= m_ts && mk < m_te);
  endtask

  task automatic sync_then(input int n, input string tag);
    fsync = 1'b1;
    step(tag);
    fsync = 1'b0;
    repeat (n) step(tag);
  endtask

  initial begin
    #(20 * 190000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fsync = 1'b0; marm = 1'b0; mk = 0;
    m_rs = 0; m_re = 0; m_ts = 0; m_te = 0;
    set_cfg(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R1 reset", "rx_win", rx_win, 1'b0);
    check("R1 reset", "tx_win", tx_win, 1'b0);
    rst_n = 1'b1;
    repeat (20) step("R1 no sync yet");

    // Table of settings, one frame each: R2 position, R3 width, R4 independence
    for (int i = 0; i < 8; i++) begin
      set_cfg(int'(VEC[i][43:38]), int'(VEC[i][37:35]), int'(VEC[i][34:27]),
              int'(VEC[i][26:21]), int'(VEC[i][20:18]), int'(VEC[i][17:10]));
      sync_then(int'(VEC[i][9:0]) - 1, "R2 R3 R4 table");
    end

    // R8 extremes: position 0 with width 1, position 511 with width 256
    set_cfg(0, 0, 0, 63, 7, 255);
    sync_then(799, "R8 extremes");

    // R5: settings changed mid-frame leave the running frame alone
    set_cfg(2, 0, 3, 1, 1, 7);
    sync_then(5, "R5 mid-frame write");
    set_cfg(0, 0, 0, 0, 0, 0);
    repeat (40) step("R5 mid-frame write");

    // R6: sync lands inside an open window
    set_cfg(0, 0, 50, 0, 4, 50);
    sync_then(10, "R6 sync in window");
    sync_then(70, "R6 sync in window");

    // R6: sync lands on the edge where the window would open (start 17)
    set_cfg(2, 0, 5, 2, 0, 5);
    sync_then(16, "R6 sync at open");
    sync_then(30, "R6 sync at open");

    // R7: one sync, then a very long frame that saturates the count
    set_cfg(1, 0, 3, 0, 2, 9);
    sync_then(2100, "R7 long frame");

    // R1: asynchronous reset in the middle of an open window
    set_cfg(0, 0, 100, 0, 0, 100);
    sync_then(20, "R1 async reset");
    rst_n = 1'b0;
    marm  = 1'b0;
    #1;
    check("R1 async reset", "rx_win", rx_win, 1'b0);
    check("R1 async reset", "tx_win", tx_win, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) step("R1 after reset");

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

endmodule